// File: doc/BRIEF.md
# Debug Interrupt Entry Controller

This block manages processor state when a debug event is taken and when the return-from-critical-interrupt operation later runs. Event detectors raise one pulse per event type. While the debug enable bit of the machine state register is set, the block picks one pending event by a fixed priority. It records a return address that depends on the class of that event, keeps a copy of the full state register, and produces a new state value with a fixed group of control bits cleared. It also sets a sticky status bit that names the event and redirects the program counter to the debug handler. The handler address is the upper half of the vector prefix register joined with 0x2000.

The return operation redirects the program counter to the saved return address and hands back the saved state register. The machine state register itself sits outside the block. The block drives a write strobe and write data for it, and that register feeds the state back as an input. The status register is cleared by writing ones to its clear port.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: Event indices are 0 branch-taken, 1 data-address match, 2 data-value match, 3 instruction-address match, 4 instruction-completion, 5 trap (the synchronous group), 6 exception and 7 unconditional (the asynchronous group). Any synchronous event wins over any asynchronous one.
- R2: When several events are pending in one cycle, exactly one is taken, and it is the one with the lowest index.
- R3: For events 0, 1, 3 and 5 the saved return address is `cur_pc`.
- R4: For events 2 and 4 the saved return address is `seq_pc`, the address of the following instruction.
- R5: For event 6 the saved return address is `exc_vec`. For event 7 it is `next_pc`.
- R6: The saved return address and a copy of the whole `msr_in` value appear on `save_addr` and `save_state` one cycle after the event is taken.
- R7: In the cycle an event is taken, `msr_wr_vld` is 1 and `msr_wr_data` equals `msr_in & ~32'h020E_EF30`. This clears the debug enable bit 9, and bit 12 (machine-check enable) and all bits outside the mask keep their values.
- R8: In the cycle an event is taken, `redirect_vld` is 1 and `redirect_pc` is `{vec_base[31:16], 16'h2000}`.
- R9: Taking event k sets `status` bit k one cycle later. Status bits are sticky until a 1 is written to the same bit of `status_clr`. If a set and a clear hit the same bit in one cycle, the set wins.
- R10: While `msr_in` bit 9 is 0, event pulses are ignored. No redirect or state write occurs, and `save_addr`, `save_state` and `status` keep their values.
- R11: When `rfci` is 1, `redirect_vld` and `msr_wr_vld` are 1 in that cycle, with `redirect_pc` equal to `save_addr` and `msr_wr_data` equal to `save_state`. Events pending in that cycle are dropped.
- R12: After reset, `save_addr`, `save_state` and `status` are 0, and no redirect or state write is signalled while no event or return is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 8 | One pulse per debug event type, indexed as in R1 |
| cur_pc | input | 32 | Address of the instruction that caused the event |
| seq_pc | input | 32 | Address of the instruction after the causing one |
| next_pc | input | 32 | Address of the next instruction to execute |
| exc_vec | input | 32 | Vector address of the exception behind an exception event |
| msr_in | input | 32 | Current machine state register |
| vec_base | input | 32 | Vector prefix register; only the upper 16 bits are used |
| rfci | input | 1 | Return-from-critical-interrupt operation |
| status_clr | input | 8 | Write-one-to-clear mask for the status bits |
| redirect_vld | output | 1 | Program counter redirect strobe |
| redirect_pc | output | 32 | Redirect target |
| msr_wr_vld | output | 1 | State register write strobe |
| msr_wr_data | output | 32 | State register write value |
| save_addr | output | 32 | Saved return address |
| save_state | output | 32 | Saved state register |
| status | output | 8 | Sticky debug status bits |

## Verification
The redirect and state-write outputs are combinational from the event pulses, `rfci` and `msr_in`, so they are due in the same cycle as the stimulus. `save_addr`, `save_state` and `status` come from registers and are due one clock edge later. The bench drives inputs on the falling edge. It samples the combinational results one nanosecond after driving them, and samples the registered results at the following falling edge, after exactly one rising edge. The bench keeps its own model of the external state register and loads it on each write strobe. This makes the clearing of the debug enable bit on entry, and its restoration on return, visible in the next cycle.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

    localparam int unsigned MSR_W     = 32;
    localparam int unsigned NUM_EVT   = 8;
    localparam int unsigned EVT_IDX_W = $clog2(NUM_EVT);

    // Machine state bit positions the block depends on
    localparam int unsigned DBG_EN_BIT = 9;
    localparam int unsigned MCHK_BIT   = 12;

    // Bits cleared on debug entry: 25,19,18,17,15,14,13,11,10,9,8,5,4
    localparam logic [MSR_W-1:0] ENTRY_CLR_MASK = 32'h020E_EF30;

    // Lower index = higher priority; synchronous events come first
    typedef enum logic [EVT_IDX_W-1:0] {
        EV_BRANCH = 3'd0,
        EV_DADDR  = 3'd1,
        EV_DVAL   = 3'd2,
        EV_IADDR  = 3'd3,
        EV_ICOMP  = 3'd4,
        EV_TRAP   = 3'd5,
        EV_EXCPT  = 3'd6,
        EV_UNCOND = 3'd7
    } evt_e;

    typedef enum logic [1:0] {
        RA_CAUSE,
        RA_FOLLOW,
        RA_VECTOR,
        RA_NEXT
    } ret_src_e;

    typedef struct packed {
        logic vld;
        evt_e id;
    } grant_t;

    function automatic ret_src_e ret_src_of(evt_e e);
        case (e)
            EV_DVAL, EV_ICOMP: ret_src_of = RA_FOLLOW;
            EV_EXCPT:          ret_src_of = RA_VECTOR;
            EV_UNCOND:         ret_src_of = RA_NEXT;
            default:           ret_src_of = RA_CAUSE;
        endcase
    endfunction

    function automatic logic [MSR_W-1:0] entry_state(logic [MSR_W-1:0] cur);
        entry_state = cur & ~ENTRY_CLR_MASK;
    endfunction

endpackage

// File: rtl/dbg_evt_arbiter.sv
module dbg_evt_arbiter
    import dbg_entry_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] req,
    input  logic               enable,
    output grant_t             grant,
    output logic [NUM_EVT-1:0] grant_vec
);

    logic [NUM_EVT-1:0] live;
    logic [NUM_EVT:0]   blocked;

    assign live       = req & {NUM_EVT{enable}};
    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_prio
        assign grant_vec[i]  = live[i] & ~blocked[i];
        assign blocked[i+1]  = blocked[i] | live[i];
    end

    always_comb begin
        grant.vld = |live;
        grant.id  = EV_BRANCH;
        for (int k = NUM_EVT - 1; k >= 0; k--) begin
            if (live[k]) grant.id = evt_e'(k[EVT_IDX_W-1:0]);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec)) else $error("grant not one-hot"); // R2

    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        grant.vld |-> ((live & ((NUM_EVT'(1) << grant.id) - NUM_EVT'(1))) == '0))
        else $error("lower-index event passed over"); // R1

    AST_GRANT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (grant_vec == '0)) else $error("grant while disabled"); // R10

endmodule

// File: rtl/dbg_ret_select.sv
module dbg_ret_select
    import dbg_entry_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  evt_e          id,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] seq_pc,
    input  logic [AW-1:0] next_pc,
    input  logic [AW-1:0] exc_vec,
    output logic [AW-1:0] ret_addr
);

    ret_src_e src;

    always_comb begin
        src = ret_src_of(id);
        unique case (src)
            RA_FOLLOW: ret_addr = seq_pc;
            RA_VECTOR: ret_addr = exc_vec;
            RA_NEXT:   ret_addr = next_pc;
            default:   ret_addr = cur_pc;
        endcase
    end

endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
    import dbg_entry_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] set,
    input  logic [NUM_EVT-1:0] clr,
    output logic [NUM_EVT-1:0] bits
);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         bits[i] <= 1'b0;
            else if (set[i]) bits[i] <= 1'b1;
            else if (clr[i]) bits[i] <= 1'b0;
        end
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((bits & $past(bits & ~clr)) == $past(bits & ~clr)))
        else $error("status bit lost without clear"); // R9

    AST_STATUS_SET: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((bits & $past(set)) == $past(set)))
        else $error("status bit not set"); // R9

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned PREFIX_W = 16,
    parameter logic [AW-PREFIX_W-1:0] VEC_LOW = 'h2000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [AW-1:0]      cur_pc,
    input  logic [AW-1:0]      seq_pc,
    input  logic [AW-1:0]      next_pc,
    input  logic [AW-1:0]      exc_vec,
    input  logic [MSR_W-1:0]   msr_in,
    input  logic [AW-1:0]      vec_base,
    input  logic               rfci,
    input  logic [NUM_EVT-1:0] status_clr,
    output logic               redirect_vld,
    output logic [AW-1:0]      redirect_pc,
    output logic               msr_wr_vld,
    output logic [MSR_W-1:0]   msr_wr_data,
    output logic [AW-1:0]      save_addr,
    output logic [MSR_W-1:0]   save_state,
    output logic [NUM_EVT-1:0] status
);

    localparam int unsigned LOW_W = AW - PREFIX_W;

    grant_t             grant;
    logic [NUM_EVT-1:0] grant_vec;
    logic [NUM_EVT-1:0] status_set;
    logic [AW-1:0]      ret_addr;
    logic               take;
    logic               arb_en;

    assign arb_en = msr_in[DBG_EN_BIT] & ~rfci;

    dbg_evt_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (evt),
        .enable    (arb_en),
        .grant     (grant),
        .grant_vec (grant_vec)
    );

    dbg_ret_select #(.AW(AW)) u_sel (
        .id       (grant.id),
        .cur_pc   (cur_pc),
        .seq_pc   (seq_pc),
        .next_pc  (next_pc),
        .exc_vec  (exc_vec),
        .ret_addr (ret_addr)
    );

    assign take       = grant.vld;
    assign status_set = take ? grant_vec : '0;

    dbg_status_reg u_stat (
        .clk  (clk),
        .rst  (rst),
        .set  (status_set),
        .clr  (status_clr),
        .bits (status)
    );

    always_comb begin
        redirect_vld = take | rfci;
        msr_wr_vld   = take | rfci;
        if (rfci) begin
            redirect_pc = save_addr;
            msr_wr_data = save_state;
        end else begin
            redirect_pc = {vec_base[AW-1:LOW_W], VEC_LOW};
            msr_wr_data = entry_state(msr_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            save_addr  <= '0;
            save_state <= '0;
        end else if (take) begin
            save_addr  <= ret_addr;
            save_state <= msr_in;
        end
    end

    AST_SAVE_STATE: assert property (@(posedge clk) disable iff (rst)
        take |=> (save_state == $past(msr_in))) else $error("state not saved"); // R6

    AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        take |-> (((msr_wr_data & ENTRY_CLR_MASK) == '0) &&
                  (msr_wr_data[MCHK_BIT] == msr_in[MCHK_BIT])))
        else $error("entry state bits wrong"); // R7

    AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!msr_in[DBG_EN_BIT] && !rfci) |=> ($stable(save_addr) && $stable(save_state)))
        else $error("saved state changed while disabled"); // R10

    AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
        rfci |-> (redirect_vld && msr_wr_vld && status_set == '0))
        else $error("return handling wrong"); // R11

endmodule

// File: tb/dbg_entry_ctrl_test.sv
module dbg_entry_ctrl_test;
    import dbg_entry_pkg::*;

    localparam logic [31:0] CUR  = 32'h0001_0100;
    localparam logic [31:0] SEQ  = 32'h0001_0104;
    localparam logic [31:0] NXT  = 32'h0001_0200;
    localparam logic [31:0] EXC  = 32'h0000_0700;
    localparam logic [31:0] BASE = 32'hABCD_5678;
    localparam logic [31:0] HND  = 32'hABCD_2000;
    localparam logic [31:0] MASK = 32'h020E_EF30;
    localparam logic [31:0] MSR0 = 32'h8200_1A31;

    typedef struct packed {
        logic [7:0] ev;
        logic [2:0] idx;
        logic [1:0] src; // 0 cur, 1 seq, 2 exc, 3 next
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 3'd0, 2'd0}, // R3
        '{8'h02, 3'd1, 2'd0}, // R3
        '{8'h04, 3'd2, 2'd1}, // R4
        '{8'h08, 3'd3, 2'd0}, // R3
        '{8'h10, 3'd4, 2'd1}, // R4
        '{8'h20, 3'd5, 2'd0}, // R3
        '{8'h40, 3'd6, 2'd2}, // R5
        '{8'h80, 3'd7, 2'd3}, // R5
        '{8'hC4, 3'd2, 2'd1}, // R1
        '{8'h28, 3'd3, 2'd0}, // R2
        '{8'hC0, 3'd6, 2'd2}, // R2
        '{8'hFF, 3'd0, 2'd0}  // R2
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt = '0;
    logic [31:0] msr_reg = MSR0;
    logic        rfci = 1'b0;
    logic [7:0]  status_clr = '0;
    logic        redirect_vld, msr_wr_vld;
    logic [31:0] redirect_pc, msr_wr_data, save_addr, save_state;
    logic [7:0]  status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dbg_entry_ctrl uut (
        .clk(clk), .rst(rst), .evt(evt), .cur_pc(CUR), .seq_pc(SEQ),
        .next_pc(NXT), .exc_vec(EXC), .msr_in(msr_reg), .vec_base(BASE),
        .rfci(rfci), .status_clr(status_clr), .redirect_vld(redirect_vld),
        .redirect_pc(redirect_pc), .msr_wr_vld(msr_wr_vld),
        .msr_wr_data(msr_wr_data), .save_addr(save_addr),
        .save_state(save_state), .status(status)
    );

    // external state register model
    always @(posedge clk) if (!rst && msr_wr_vld) msr_reg <= msr_wr_data;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    function automatic logic [31:0] src_addr(input logic [1:0] s);
        case (s)
            2'd1:    return SEQ;
            2'd2:    return EXC;
            2'd3:    return NXT;
            default: return CUR;
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] pre;
        logic [31:0] keep;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(save_addr == 0, "R12 save_addr", save_addr, 0);
        chk(save_state == 0, "R12 save_state", save_state, 0);
        chk(status == 0, "R12 status", {24'd0, status}, 0);
        chk(!redirect_vld && !msr_wr_vld, "R12 idle", {31'd0, redirect_vld}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] ea;
            ea  = src_addr(VECS[i].src);
            pre = msr_reg;
            @(negedge clk);
            evt = VECS[i].ev;
            #1;
            chk(redirect_vld, "R8 redirect_vld", {31'd0, redirect_vld}, 1);
            chk(redirect_pc == HND, "R8 handler pc", redirect_pc, HND);
            chk(msr_wr_vld && msr_wr_data == (pre & ~MASK), "R7 entry state", msr_wr_data, pre & ~MASK);
            @(negedge clk);
            evt = '0;
            chk(save_addr == ea, "R3/R4/R5 return addr", save_addr, ea);
            chk(save_state == pre, "R6 saved state", save_state, pre);
            chk(status == (8'h01 << VECS[i].idx), "R2 status bit", {24'd0, status}, {24'd0, 8'h01 << VECS[i].idx});
            chk(msr_reg[9] == 1'b0, "R7 debug enable cleared", msr_reg, pre & ~MASK);
            rfci = 1'b1;
            #1;
            chk(redirect_vld && redirect_pc == ea, "R11 return pc", redirect_pc, ea);
            chk(msr_wr_vld && msr_wr_data == pre, "R11 return state", msr_wr_data, pre);
            @(negedge clk);
            rfci = 1'b0;
            status_clr = 8'hFF;
            @(negedge clk);
            status_clr = '0;
            chk(status == 0 && msr_reg == pre, "R9 clear and restore", {24'd0, status}, 0);
        end

        // R10: debug enable low
        msr_reg = MSR0 & ~32'h0000_0200;
        keep = save_addr;
        @(negedge clk);
        evt = 8'h01;
        #1;
        chk(!redirect_vld && !msr_wr_vld, "R10 no redirect", {31'd0, redirect_vld}, 0);
        @(negedge clk);
        evt = '0;
        chk(status == 0, "R10 status untouched", {24'd0, status}, 0);
        chk(save_addr == keep, "R10 save_addr kept", save_addr, keep);
        msr_reg = MSR0;

        // R10: event during handler ignored; R9 sticky
        @(negedge clk);
        evt = 8'h10;
        @(negedge clk);
        evt = 8'h01;
        #1;
        chk(!redirect_vld, "R10 ignored in handler", {31'd0, redirect_vld}, 0);
        @(negedge clk);
        evt = '0;
        chk(save_addr == SEQ, "R10 handler save kept", save_addr, SEQ);
        chk(status == 8'h10, "R9 sticky", {24'd0, status}, 32'h10);

        // R11: rfci beats a pending event
        msr_reg = MSR0;
        @(negedge clk);
        rfci = 1'b1;
        evt = 8'h01;
        #1;
        chk(redirect_pc == SEQ, "R11 rfci priority pc", redirect_pc, SEQ);
        @(negedge clk);
        rfci = 1'b0;
        evt = '0;
        chk(status == 8'h10, "R11 event dropped", {24'd0, status}, 32'h10);

        // R9: set wins over clear on same bit, other bit clears
        msr_reg = MSR0;
        @(negedge clk);
        evt = 8'h02;
        status_clr = 8'h12;
        @(negedge clk);
        evt = '0;
        status_clr = '0;
        chk(status == 8'h02, "R9 set beats clear", {24'd0, status}, 32'h02);

        // R7: all ones state, machine-check kept
        msr_reg = 32'hFFFF_FFFF;
        @(negedge clk);
        evt = 8'h80;
        #1;
        chk(msr_wr_data == 32'hFDF1_10CF, "R7 mask all ones", msr_wr_data, 32'hFDF1_10CF);
        @(negedge clk);
        evt = '0;
        chk(save_addr == NXT, "R5 unconditional", save_addr, NXT);

        // R12: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(status == 0 && save_addr == 0 && save_state == 0, "R12 reset again", save_addr, 0);

        finish_run();
    end

endmodule